// File: doc/BRIEF.md
# Self-Refreshing Row Memory Sequencer for a Segment Driver

This block sits behind the column shift register of an LCD segment driver. It holds a full image of up to 200 rows by 80 columns in on-chip storage. Each time the line strobe falls, it copies the addressed row into an output latch. It then stores the freshly shifted row into that same row and steps the row pointer. A scan-start level seen at the same strobe edge points the sequencer back at row 0. The number of strobes between scan starts therefore sets the active duty, anywhere from 1/64 to 1/200.

While the controller keeps sending shift clocks, each row is rewritten once per frame. When a whole line period passes without a single shift-clock edge, that line runs in self-refresh: the stored row is still read and the pointer still advances, but nothing is written. A static image is then redrawn from internal storage with no data traffic. The line strobe, scan start and shift clock are asynchronous and are synchronised into one fast system clock. Edges are detected after synchronisation.

Each latched bit is combined with the AC-drive phase and an active-low blank input to form a 2-bit select code for one of four drive levels per column.

Top module: `line_mem_ctrl`

## Requirements
- R1: After reset the row pointer is 0 and no write is pending. Every column outputs code 00 (V0) until the first row has been latched.
- R2: A falling line strobe loads the latch with the row content as it was before that strobe. The read comes before the write to the same row.
- R3: If at least one falling shift-clock edge occurred since the previous falling line strobe, the value on `row_data_i` at that strobe is written into the row just read.
- R4: After each falling line strobe the row pointer advances by one. It wraps from ROWS-1 to 0.
- R5: If `scan_start_i` is high when the line strobe falls, that line reads and writes row 0, and the next line uses row 1.
- R6: If no falling shift-clock edge occurred in the line period, the strobe still reads and advances, but the stored row is left unchanged (self-refresh).
- R7: One line period with shift activity after self-refresh is enough: that period's row is written at the strobe that closes it.
- R8: With `blank_n_i` high, each column's 2-bit code is set by the latched bit and `phase_i`. Bit 1 with phase 1 gives 00 (V0). Bit 1 with phase 0 gives 11 (V5). Bit 0 with phase 1 gives 01 (V2). Bit 0 with phase 0 gives 10 (V3). Column c occupies `drive_sel_o[2c+1:2c]`.
- R9: With `blank_n_i` low, every column outputs 00. Storage is unaffected, and blanking works in self-refresh.
- R10: Between falling line strobes the latch does not change. Shift-clock activity alone never alters the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_pulse_i | input | 1 | Line strobe, acts on its falling edge |
| scan_start_i | input | 1 | Frame start level, sampled at the line strobe fall |
| shift_clk_i | input | 1 | Column shift clock, watched for falling edges |
| blank_n_i | input | 1 | Active-low forced blank |
| phase_i | input | 1 | AC-drive phase |
| row_data_i | input | COLS | Contents of the shifted column register |
| drive_sel_o | output | 2*COLS | Per-column drive level select code |

## Verification
The bench runs several frames with all shift clocks present, then frames with none. It changes the data presented on idle frames, so a design that writes during self-refresh shows the wrong image in the following frame. It mixes active and idle lines inside one frame to catch a sequencer that latches the mode per frame instead of per line. It also raises scan start in the middle of a frame, and it walks the pointer through all 200 rows without a scan start. A pointer that fails to wrap, or one that resets too late, then displays another row's pattern. Blanking is held across a writing frame, and the content is read back afterwards. Phase is swept against known rows to pin down the four-code table.

// File: rtl/lm_pkg.sv
package lm_pkg;

  typedef enum logic [1:0] {
    LV_V0 = 2'b00,
    LV_V2 = 2'b01,
    LV_V3 = 2'b10,
    LV_V5 = 2'b11
  } drive_lvl_e;

  typedef enum logic {
    SEQ_IDLE   = 1'b0,
    SEQ_COMMIT = 1'b1
  } seq_state_e;

  function automatic drive_lvl_e pick_level(input logic blank_n,
                                            input logic bit_on,
                                            input logic ph);
    drive_lvl_e lv;
    if (!blank_n) lv = LV_V0;
    else begin
      unique case ({bit_on, ph})
        2'b11:   lv = LV_V0;
        2'b10:   lv = LV_V5;
        2'b01:   lv = LV_V2;
        default: lv = LV_V3;
      endcase
    end
    return lv;
  endfunction

endpackage

// File: rtl/lm_edge_sync.sv
module lm_edge_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] EDGE_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;
    logic              lvl;

    always_comb chain_d = {chain_q[STAGES-2:0], async_i[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign lvl = chain_q[STAGES-1];

    if (EDGE_MASK[g]) begin : g_fall
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
      end
      assign sync_o[g] = prev_q & ~lvl;
    end else begin : g_level
      assign sync_o[g] = lvl;
    end
  end

endmodule

// File: rtl/lm_row_sequencer.sv
module lm_row_sequencer
  import lm_pkg::*;
#(
  parameter int ROWS = 200,
  parameter int AW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_fall_i,
  input  logic          scan_i,
  input  logic          shift_fall_i,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          we_o,
  output logic [AW-1:0] wr_addr_o
);

  localparam logic [AW-1:0] LAST_ROW = AW'(ROWS - 1);

  seq_state_e    state_q, state_d;
  logic [AW-1:0] row_q, row_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          act_q, act_d;
  logic          pend_q, pend_d;

  always_comb begin
    rd_en_o   = line_fall_i;
    rd_addr_o = scan_i ? '0 : row_q;
    we_o      = (state_q == SEQ_COMMIT) && pend_q;
    wr_addr_o = addr_q;
  end

  always_comb begin
    state_d = line_fall_i ? SEQ_COMMIT : SEQ_IDLE;
    addr_d  = addr_q;
    pend_d  = pend_q;
    act_d   = act_q | shift_fall_i;
    row_d   = row_q;
    if (line_fall_i) begin
      addr_d = rd_addr_o;
      pend_d = act_q;
      act_d  = shift_fall_i;
    end
    if (state_q == SEQ_COMMIT) begin
      row_d = (addr_q == LAST_ROW) ? '0 : addr_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      row_q   <= '0;
      addr_q  <= '0;
      act_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      row_q   <= row_d;
      addr_q  <= addr_d;
      act_q   <= act_d;
      pend_q  <= pend_d;
    end
  end

  // R4: pointer always stays inside the array
  a_r4_row_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    row_q <= LAST_ROW);

  // R5: scan start at the strobe selects row 0 for that line
  a_r5_scan_row0: assert property (@(posedge clk) disable iff (!rst_n)
    line_fall_i && scan_i |=> addr_q == '0);

  // R3: a write only follows directly after a line strobe
  a_r3_write_after_line: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |-> $past(line_fall_i));

  // R6: an idle period produces no write
  a_r6_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    line_fall_i && !act_q |=> !we_o);

  // R7: any shift edge marks the period as active
  a_r7_shift_marks: assert property (@(posedge clk) disable iff (!rst_n)
    shift_fall_i |=> act_q);

endmodule

// File: rtl/lm_line_store.sv
module lm_line_store #(
  parameter int ROWS = 200,
  parameter int COLS = 80,
  parameter int AW = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_en_i,
  input  logic [AW-1:0]   rd_addr_i,
  input  logic            we_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [COLS-1:0] row_data_i,
  output logic [COLS-1:0] latch_o,
  output logic            shown_o
);

  logic [COLS-1:0] mem_q [ROWS];
  logic [COLS-1:0] wreg_q, wreg_d;
  logic [COLS-1:0] latch_q, latch_d;
  logic            shown_q, shown_d;

  always_comb begin
    wreg_d  = wreg_q;
    latch_d = latch_q;
    shown_d = shown_q;
    if (rd_en_i) begin
      wreg_d  = row_data_i;
      latch_d = mem_q[rd_addr_i];
      shown_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wreg_q  <= '0;
      latch_q <= '0;
      shown_q <= 1'b0;
    end else begin
      wreg_q  <= wreg_d;
      latch_q <= latch_d;
      shown_q <= shown_d;
    end
  end

  always_ff @(posedge clk) begin
    if (we_i) mem_q[wr_addr_i] <= wreg_q;
  end

  assign latch_o = latch_q;
  assign shown_o = shown_q;

  // R10: latch only moves on a line read
  a_r10_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(latch_q));

  // R2: read and write never collide in one cycle
  a_r2_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en_i && we_i));

endmodule

// File: rtl/lm_level_map.sv
module lm_level_map
  import lm_pkg::*;
#(
  parameter int COLS = 80
) (
  input  logic [COLS-1:0]   latch_i,
  input  logic              shown_i,
  input  logic              blank_n_i,
  input  logic              phase_i,
  output logic [2*COLS-1:0] sel_o
);

  for (genvar c = 0; c < COLS; c++) begin : g_col
    drive_lvl_e lv;
    always_comb lv = shown_i ? pick_level(blank_n_i, latch_i[c], phase_i) : LV_V0;
    assign sel_o[2*c +: 2] = lv;
  end

endmodule

// File: rtl/line_mem_ctrl.sv
module line_mem_ctrl #(
  parameter int ROWS = 200,
  parameter int COLS = 80,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_pulse_i,
  input  logic              scan_start_i,
  input  logic              shift_clk_i,
  input  logic              blank_n_i,
  input  logic              phase_i,
  input  logic [COLS-1:0]   row_data_i,
  output logic [2*COLS-1:0] drive_sel_o
);

  localparam int AW = $clog2(ROWS);
  localparam int IDX_LINE = 0;
  localparam int IDX_SCAN = 1;
  localparam int IDX_SHIFT = 2;
  localparam logic [2:0] FALL_MASK = 3'b101;

  logic [2:0]      sync_vec;
  logic            rd_en, we;
  logic [AW-1:0]   rd_addr, wr_addr;
  logic [COLS-1:0] latch;
  logic            shown;

  lm_edge_sync #(
    .WIDTH(3), .STAGES(SYNC_STAGES), .EDGE_MASK(FALL_MASK)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({shift_clk_i, scan_start_i, line_pulse_i}),
    .sync_o  (sync_vec)
  );

  lm_row_sequencer #(.ROWS(ROWS), .AW(AW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_fall_i  (sync_vec[IDX_LINE]),
    .scan_i       (sync_vec[IDX_SCAN]),
    .shift_fall_i (sync_vec[IDX_SHIFT]),
    .rd_en_o      (rd_en),
    .rd_addr_o    (rd_addr),
    .we_o         (we),
    .wr_addr_o    (wr_addr)
  );

  lm_line_store #(.ROWS(ROWS), .COLS(COLS), .AW(AW)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en_i    (rd_en),
    .rd_addr_i  (rd_addr),
    .we_i       (we),
    .wr_addr_i  (wr_addr),
    .row_data_i (row_data_i),
    .latch_o    (latch),
    .shown_o    (shown)
  );

  lm_level_map #(.COLS(COLS)) u_map (
    .latch_i   (latch),
    .shown_i   (shown),
    .blank_n_i (blank_n_i),
    .phase_i   (phase_i),
    .sel_o     (drive_sel_o)
  );

  // R1: nothing but V0 before the first latched row
  a_r1_idle_v0: assert property (@(posedge clk) disable iff (!rst_n)
    !shown |-> drive_sel_o == '0);

  // R9: blanking forces V0 on every column
  a_r9_blank_v0: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n_i |-> drive_sel_o == '0);

endmodule

// File: tb/line_mem_ctrl_tb_top.sv
module line_mem_ctrl_tb_top;

  localparam int ROWS = 200;
  localparam int COLS = 80;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              line_pulse_i, scan_start_i, shift_clk_i, blank_n_i, phase_i;
  logic [COLS-1:0]   row_data_i;
  logic [2*COLS-1:0] drive_sel_o;

  always #4 clk = ~clk;

  line_mem_ctrl dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_pulse_i (line_pulse_i),
    .scan_start_i (scan_start_i),
    .shift_clk_i  (shift_clk_i),
    .blank_n_i    (blank_n_i),
    .phase_i      (phase_i),
    .row_data_i   (row_data_i),
    .drive_sel_o  (drive_sel_o)
  );

  // reference state
  logic [COLS-1:0] mem_m [ROWS];
  logic [COLS-1:0] exp_lat;
  bit              exp_shown;
  int              row_m;
  bit              act_m;
  bit              chk_en;
  bit              done;
  string           cur_req;
  int              n_vec, n_bad, cycles;

  function automatic logic [COLS-1:0] mk(input int s);
    logic [31:0] a, b;
    a = s * 32'h9e3779b1;
    b = (s * 32'h85ebca6b) ^ 32'h0000ffff;
    return {a, b, 16'(s + 16'h5a00)};
  endfunction

  function automatic logic [2*COLS-1:0] expect_out();
    logic [2*COLS-1:0] v;
    v = '0;
    if (exp_shown && blank_n_i) begin
      for (int c = 0; c < COLS; c++) begin
        if (exp_lat[c] && phase_i)       v[2*c +: 2] = 2'd0;
        else if (exp_lat[c])             v[2*c +: 2] = 2'd3;
        else if (phase_i)                v[2*c +: 2] = 2'd1;
        else                             v[2*c +: 2] = 2'd2;
      end
    end
    return v;
  endfunction

  // compare on every clock, just after the edge has settled
  always @(posedge clk) begin
    #1;
    if (chk_en && !done) begin
      if (!(exp_shown && blank_n_i && $isunknown(exp_lat))) begin
        logic [2*COLS-1:0] e;
        e = expect_out();
        n_vec++;
        if (drive_sel_o !== e) begin
          n_bad++;
          $display("FAIL %s: drive_sel_o=%h expected %h", cur_req, drive_sel_o, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic pulse_shift();
    shift_clk_i = 1'b1;
    repeat (2) @(negedge clk);
    shift_clk_i = 1'b0;
    repeat (2) @(negedge clk);
    act_m = 1'b1;
  endtask

  task automatic do_line(input logic [COLS-1:0] d, input int nshift, input bit scan);
    int r;
    @(negedge clk);
    row_data_i   = d;
    scan_start_i = scan;
    for (int k = 0; k < nshift; k++) pulse_shift();
    line_pulse_i = 1'b1;
    repeat (3) @(negedge clk);
    chk_en = 1'b0;
    line_pulse_i = 1'b0;
    repeat (5) @(negedge clk);
    r = scan ? 0 : row_m;
    exp_lat = mem_m[r];
    if (act_m) mem_m[r] = d;
    act_m = 1'b0;
    row_m = (r == ROWS - 1) ? 0 : r + 1;
    exp_shown = 1'b1;
    chk_en = 1'b1;
    scan_start_i = 1'b0;
  endtask

  initial begin
    n_vec = 0; n_bad = 0; cycles = 0; done = 1'b0; chk_en = 1'b0;
    for (int i = 0; i < ROWS; i++) mem_m[i] = 'x;
    exp_lat = '0; exp_shown = 1'b0; row_m = 0; act_m = 1'b0;
    rst_n = 1'b0; line_pulse_i = 1'b0; scan_start_i = 1'b0; shift_clk_i = 1'b0;
    blank_n_i = 1'b1; phase_i = 1'b0; row_data_i = '0;
    cur_req = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    chk_en = 1'b1;
    repeat (6) @(negedge clk);
    phase_i = 1'b1;
    repeat (6) @(negedge clk);
    phase_i = 1'b0;

    // frame with data transfer: R3
    cur_req = "R3";
    for (int i = 0; i < 4; i++) do_line(mk(i), 2, i == 0);

    // idle frame shows stored rows: R2
    cur_req = "R2";
    for (int i = 0; i < 4; i++) do_line(mk(100 + i), 0, i == 0);

    // second idle frame: nothing was written: R6
    cur_req = "R6";
    for (int i = 0; i < 4; i++) do_line(mk(200 + i), 0, i == 0);

    // mixed active and idle lines: R7
    cur_req = "R7";
    for (int i = 0; i < 4; i++) do_line(mk(300 + i), (i % 2 == 0) ? 1 : 0, i == 0);

    // phase sweep on known rows: R8
    cur_req = "R8";
    for (int i = 0; i < 4; i++) begin
      do_line(mk(400 + i), 0, i == 0);
      phase_i = 1'b1;
      repeat (3) @(negedge clk);
      phase_i = 1'b0;
      repeat (3) @(negedge clk);
    end

    // shift activity alone changes nothing: R10
    cur_req = "R10";
    for (int k = 0; k < 3; k++) pulse_shift();
    row_data_i = mk(999);
    repeat (8) @(negedge clk);
    do_line(mk(500), 0, 1'b1);

    // blanked writing frame, then read back unblanked: R9
    cur_req = "R9";
    blank_n_i = 1'b0;
    for (int i = 1; i < 4; i++) do_line(mk(600 + i), 1, 1'b0);
    do_line(mk(600), 1, 1'b1);
    for (int i = 1; i < 4; i++) do_line(mk(700 + i), 0, 1'b0);
    blank_n_i = 1'b1;
    for (int i = 0; i < 4; i++) do_line(mk(800 + i), 0, i == 0);

    // scan start in mid frame: R5
    cur_req = "R5";
    do_line(mk(900), 0, 1'b1);
    do_line(mk(901), 0, 1'b0);
    do_line(mk(902), 1, 1'b1);
    do_line(mk(903), 0, 1'b0);
    do_line(mk(904), 0, 1'b0);

    // full pointer walk with wrap: R4
    cur_req = "R4";
    for (int i = 0; i < ROWS; i++) do_line(mk(1000 + row_m), 1, 1'b0);
    for (int i = 0; i < ROWS + 3; i++) do_line(mk(5000 + i), 0, 1'b0);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule